// File: doc/BRIEF.md
# Scan-Cycle SPI Program Fetch Sequencer

This block streams a control program out of a serial EEPROM with 16-bit addressing and hands it, one byte at a time, to an execution core together with each byte's address. It never issues a read per byte. After a system reset it opens one read at address zero and takes the first four bytes as a boot header. The header holds the scan start vector and the address of the last valid instruction. It then keeps SCLK running with chip select held low and relies on the memory to auto-increment.

Once the byte at the end address has been handed over, the block raises chip select for exactly one clock. During that clock it pulses an input-latch strobe so the core can freeze its inputs for the coming scan. It then reopens the memory with a read command at the start vector. An opcode whose upper nibble is 1110 carries one operand byte. That operand byte is flagged as an operand, and it is still fetched when the opcode sits at the end address.

The serial link runs in mode 0, most significant bit first. SCLK is half the system clock, so a byte takes 16 clocks.

Top module: `scan_fetch_seq`

## Requirements
- R1: While reset is high, chip select is high, SCLK is low, and neither the byte strobe nor the latch strobe is asserted.
- R2: The first transfer after reset is the command byte 0x03 followed by the 16-bit address 0x0000, sent MSB first. COPI changes only while SCLK is low, so it is stable at each rising SCLK edge.
- R3: The boot header consists of bytes 0 and 1 (start vector, high byte first) and bytes 2 and 3 (end address, high byte first). Header bytes are never delivered. The boot scan delivers from address 4 onward.
- R4: Each delivered byte carries its memory address, which rises by one per byte. Within a scan, consecutive deliveries are exactly 16 clocks apart.
- R5: The clock after the byte at the end address is delivered, chip select is high for exactly one clock. A new read 0x03 then starts at the start vector from the header.
- R6: Every scan start has exactly one latch pulse of one clock. It occurs while chip select is high, in the clock right before chip select falls.
- R7: The byte following an opcode with upper nibble 1110 is delivered with the operand flag set. That byte is never itself treated as an opcode, whatever its value.
- R8: If the byte at the end address is a 1110 opcode, its operand at the next address is still delivered, and the restart follows that operand.
- R9: SCLK is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| spi_cs_n | output | 1 | Memory chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_copi | output | 1 | Serial data to the memory |
| spi_cipo | input | 1 | Serial data from the memory |
| scan_latch | output | 1 | One-clock input-freeze strobe at each scan start |
| fetch_valid | output | 1 | Delivered byte strobe |
| fetch_data | output | 8 | Delivered byte |
| fetch_addr | output | 16 | Memory address of the delivered byte |
| fetch_operand | output | 1 | Delivered byte is the operand of a 1110 opcode |

## Verification
Three memory images are used. The first has a plain opcode stream whose vector equals the first program address. It checks the command, the addresses, the 16-clock spacing and the one-clock restart gap. The second places its vector past the first program address and embeds an operand that looks like a 1110 opcode. It also ends on a 1110 opcode. This separates the boot start from later scans, tests whether operands are mistaken for opcodes, and tests whether the end-address operand is fetched before the restart. The third has a one-byte scan where vector and end are equal, which exercises back-to-back restarts.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam logic [7:0] RD_CMD   = 8'h03;
  localparam logic [3:0] OPND_NIB = 4'b1110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_RUN
  } fseq_state_e;
endpackage

// File: rtl/fseq_spi_link.sv
module fseq_spi_link
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cipo_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              copi_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int TX_W  = 8 + ADDR_W;
  localparam int PRE_W = $clog2(TX_W + 1);
  localparam int BIT_W = $clog2(DATA_W);

  logic              cs_n_q, sclk_q, copi_q, active_q, rx_valid_q;
  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] rx_q, rx_data_q;
  logic [BIT_W-1:0]  bit_q;
  logic [PRE_W-1:0]  pre_q;

  always_ff @(posedge clk) begin
    rx_valid_q <= 1'b0;
    if (rst) begin
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b0;
      copi_q    <= 1'b0;
      active_q  <= 1'b0;
      tx_q      <= '0;
      rx_q      <= '0;
      rx_data_q <= '0;
      bit_q     <= '0;
      pre_q     <= '0;
    end else if (stop_i) begin
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b0;
      copi_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cs_n_q   <= 1'b0;
      sclk_q   <= 1'b0;
      active_q <= 1'b1;
      tx_q     <= {RD_CMD, addr_i};
      copi_q   <= RD_CMD[7];
      bit_q    <= '0;
      pre_q    <= PRE_W'(TX_W);
    end else if (active_q) begin
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        // falling edge: capture the bit read on the rising edge, shift out next
        rx_q   <= {rx_q[DATA_W-2:0], cipo_i};
        tx_q   <= tx_q << 1;
        copi_q <= tx_q[TX_W-2];
        bit_q  <= (bit_q == BIT_W'(DATA_W - 1)) ? '0 : bit_q + 1'b1;
        if (pre_q != '0) begin
          pre_q <= pre_q - 1'b1;
        end else if (bit_q == BIT_W'(DATA_W - 1)) begin
          rx_valid_q <= 1'b1;
          rx_data_q  <= {rx_q[DATA_W-2:0], cipo_i};
        end
      end
    end
  end

  assign cs_n_o     = cs_n_q;
  assign sclk_o     = sclk_q;
  assign copi_o     = copi_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              start_o,
  output logic              stop_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              latch_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              out_operand_o
);
  localparam int HDR_BITS = 2 * ADDR_W;
  localparam int HDR_N    = HDR_BITS / DATA_W;
  localparam int HDR_W    = $clog2(HDR_N + 1);

  fseq_state_e         state_q;
  logic [HDR_W-1:0]    hdr_q;
  logic [HDR_BITS-1:0] hdr_sr_q, hdr_next;
  logic [ADDR_W-1:0]   vec_q, end_q, cnt_q;
  logic                op_pend_q, end_armed_q, latch_q;
  logic                out_valid_q, out_operand_q;
  logic [DATA_W-1:0]   out_data_q;
  logic [ADDR_W-1:0]   out_addr_q;
  logic                hdr_done, deliver, is_opc, finish;

  always_comb begin
    hdr_done     = (hdr_q == HDR_W'(HDR_N));
    hdr_next     = {hdr_sr_q[HDR_BITS-DATA_W-1:0], rx_data_i};
    deliver      = (state_q == ST_RUN) && rx_valid_i && hdr_done;
    is_opc       = !op_pend_q && (rx_data_i[DATA_W-1 -: 4] == OPND_NIB);
    finish       = deliver && !is_opc && ((cnt_q == end_q) || end_armed_q);
    start_o      = (state_q == ST_GAP);
    stop_o       = finish;
    start_addr_o = hdr_done ? vec_q : '0;
  end

  always_ff @(posedge clk) begin
    out_valid_q <= 1'b0;
    latch_q     <= 1'b0;
    if (rst) begin
      state_q       <= ST_IDLE;
      hdr_q         <= '0;
      hdr_sr_q      <= '0;
      vec_q         <= '0;
      end_q         <= '0;
      cnt_q         <= '0;
      op_pend_q     <= 1'b0;
      end_armed_q   <= 1'b0;
      out_data_q    <= '0;
      out_addr_q    <= '0;
      out_operand_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_q <= ST_GAP;
          latch_q <= 1'b1;
        end
        ST_GAP: begin
          state_q     <= ST_RUN;
          cnt_q       <= start_addr_o;
          op_pend_q   <= 1'b0;
          end_armed_q <= 1'b0;
        end
        default: begin
          if (rx_valid_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (!hdr_done) begin
              hdr_q    <= hdr_q + 1'b1;
              hdr_sr_q <= hdr_next;
              if (hdr_q == HDR_W'(HDR_N - 1)) begin
                vec_q <= hdr_next[HDR_BITS-1:ADDR_W];
                end_q <= hdr_next[ADDR_W-1:0];
              end
            end else begin
              out_valid_q   <= 1'b1;
              out_data_q    <= rx_data_i;
              out_addr_q    <= cnt_q;
              out_operand_q <= op_pend_q;
              op_pend_q     <= is_opc;
              end_armed_q   <= (cnt_q == end_q);
              if (finish) begin
                state_q <= ST_GAP;
                latch_q <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assign latch_o       = latch_q;
  assign out_valid_o   = out_valid_q;
  assign out_data_o    = out_data_q;
  assign out_addr_o    = out_addr_q;
  assign out_operand_o = out_operand_q;
endmodule

// File: rtl/scan_fetch_seq.sv
module scan_fetch_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_copi,
  input  logic              spi_cipo,
  output logic              scan_latch,
  output logic              fetch_valid,
  output logic [DATA_W-1:0] fetch_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_operand
);
  logic              start_w, stop_w, rx_valid_w;
  logic [ADDR_W-1:0] start_addr_w;
  logic [DATA_W-1:0] rx_data_w;

  fseq_spi_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_link (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .addr_i     (start_addr_w),
    .cipo_i     (spi_cipo),
    .cs_n_o     (spi_cs_n),
    .sclk_o     (spi_sclk),
    .copi_o     (spi_copi),
    .rx_valid_o (rx_valid_w),
    .rx_data_o  (rx_data_w)
  );

  fseq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .rx_valid_i    (rx_valid_w),
    .rx_data_i     (rx_data_w),
    .start_o       (start_w),
    .stop_o        (stop_w),
    .start_addr_o  (start_addr_w),
    .latch_o       (scan_latch),
    .out_valid_o   (fetch_valid),
    .out_data_o    (fetch_data),
    .out_addr_o    (fetch_addr),
    .out_operand_o (fetch_operand)
  );
endmodule

// File: rtl/scan_fetch_seq_chk.sv
module scan_fetch_seq_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_copi,
  input logic scan_latch,
  input logic fetch_valid
);
  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  p_copi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_copi));

  p_latch_cs_r6: assert property (@(posedge clk) disable iff (rst)
    scan_latch |-> spi_cs_n);

  p_latch_once_r6: assert property (@(posedge clk) disable iff (rst)
    scan_latch |=> !scan_latch);

  p_gap_one_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> !spi_cs_n);

  p_end_then_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> fetch_valid);

  p_valid_space_r4: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);
endmodule

bind scan_fetch_seq scan_fetch_seq_chk u_chk (.*);

// File: tb/sim_scan_fetch_seq.sv
module sim_scan_fetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n, spi_sclk, spi_copi, scan_latch;
  logic        spi_cipo = 1'b0;
  logic        fetch_valid, fetch_operand;
  logic [7:0]  fetch_data;
  logic [15:0] fetch_addr;

  always #2 clk = ~clk;

  scan_fetch_seq u0 (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_copi(spi_copi), .spi_cipo(spi_cipo), .scan_latch(scan_latch),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_addr(fetch_addr), .fetch_operand(fetch_operand)
  );

  logic [7:0]  mem [0:63];
  logic [24:0] q_exp[$];
  string       q_req[$];
  int          checks = 0, errs = 0, cycles = 0;
  logic [15:0] vec, endp, exp_start, ptr;
  logic [23:0] shin;
  int          nin, obit, hi_run, latch_seen, scans, since;
  logic        prev_sclk, prev_cs, first_in_scan;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic op, input string req);
    q_exp.push_back({op, a, mem[a[5:0]]});
    q_req.push_back(req);
  endtask

  // expected deliveries of one scan, from the requirements
  task automatic plan_scan(input logic [15:0] from, input bit boot);
    logic [15:0] a = from;
    logic pend = 1'b0;
    bit first = 1'b1;
    forever begin
      logic opc;
      opc = !pend && (mem[a[5:0]][7:4] == 4'hE);
      push(a, pend, (boot && first) ? "R3" : (pend ? "R7" : "R4"));
      first = 1'b0;
      if (a == endp) begin
        if (opc) push(a + 16'd1, 1'b1, "R8");
        break;
      end
      pend = opc;
      a = a + 16'd1;
    end
  endtask

  // memory model plus per-clock comparison
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      nin = 0; obit = 0; hi_run = 0; latch_seen = 0; scans = 0; since = 0;
      prev_sclk = 1'b0; prev_cs = 1'b1; first_in_scan = 1'b1; exp_start = 16'h0;
      spi_cipo = 1'b0;
    end else begin
      if (spi_cs_n) begin
        nin = 0; obit = 0;
        check(!spi_sclk, "R9", spi_sclk, 0);
      end else begin
        if (spi_sclk && !prev_sclk) begin
          shin = {shin[22:0], spi_copi};
          nin++;
          if (nin == 8) check(shin[7:0] == 8'h03, "R2", shin[7:0], 8'h03);
          if (nin == 24) begin
            check(shin[15:0] == exp_start, (scans <= 1) ? "R2" : "R5", shin[15:0], exp_start);
            ptr = shin[15:0];
            exp_start = vec;
          end
        end
        if (!spi_sclk && prev_sclk && nin >= 24) begin
          spi_cipo = mem[ptr[5:0]][7-obit];
          obit++;
          if (obit == 8) begin obit = 0; ptr = ptr + 16'd1; end
        end
      end
      if (scan_latch) begin
        check(spi_cs_n, "R6", spi_cs_n, 1);
        latch_seen++;
      end
      if (spi_cs_n) hi_run++;
      if (!spi_cs_n && prev_cs) begin
        check(latch_seen == 1, "R6", latch_seen, 1);
        if (scans > 0) check(hi_run == 1, "R5", hi_run, 1);
        latch_seen = 0;
        scans++;
        first_in_scan = 1'b1;
      end
      if (!spi_cs_n) hi_run = 0;
      if (fetch_valid) begin
        if (q_exp.size() > 0) begin
          logic [24:0] e;
          string r;
          e = q_exp.pop_front();
          r = q_req.pop_front();
          check({fetch_operand, fetch_addr, fetch_data} == e, r,
                {fetch_operand, fetch_addr, fetch_data}, e);
          if (!first_in_scan) check(since == 16, "R4", since, 16);
        end
        first_in_scan = 1'b0;
        since = 1;
      end else begin
        since++;
      end
      prev_sclk = spi_sclk;
      prev_cs = spi_cs_n;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
  endtask

  task automatic run_prog(input int nscan);
    rst = 1'b1;
    q_exp.delete(); q_req.delete();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(spi_cs_n && !spi_sclk && !fetch_valid && !scan_latch, "R1",
          {spi_cs_n, spi_sclk, fetch_valid, scan_latch}, 4'b1000);
    vec  = {mem[0], mem[1]};
    endp = {mem[2], mem[3]};
    plan_scan(16'd4, 1'b1);
    for (int s = 0; s < nscan; s++) plan_scan(vec, 1'b0);
    @(posedge clk);
    rst <= 1'b0;
    for (int w = 0; w < 20000 && q_exp.size() > 0; w++) @(posedge clk);
    check(q_exp.size() == 0, "R5", q_exp.size(), 0);
  endtask

  initial begin
    // image 1: plain stream, vector at first program byte
    clear_mem();
    mem[0] = 8'h00; mem[1] = 8'h04; mem[2] = 8'h00; mem[3] = 8'h08;
    mem[4] = 8'h00; mem[5] = 8'hB5; mem[6] = 8'h18; mem[7] = 8'h8A; mem[8] = 8'h09;
    run_prog(3);
    // image 2: vector past first byte, opcode-like operand, 1110 opcode at end
    clear_mem();
    mem[0] = 8'h00; mem[1] = 8'h06; mem[2] = 8'h00; mem[3] = 8'h0C;
    mem[4] = 8'h11; mem[5] = 8'h22; mem[6] = 8'hE3; mem[7] = 8'hE5;
    mem[8] = 8'h40; mem[9] = 8'hE1; mem[10] = 8'h7F; mem[11] = 8'h12;
    mem[12] = 8'hE6; mem[13] = 8'h9C;
    run_prog(3);
    // image 3: one-byte scans, vector equals end
    clear_mem();
    mem[0] = 8'h00; mem[1] = 8'h05; mem[2] = 8'h00; mem[3] = 8'h05;
    mem[4] = 8'hAA; mem[5] = 8'h55;
    run_prog(5);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errs++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule